// File: doc/BRIEF.md
# Memory Self-Test Pattern Sequencer

This block runs the power-on data-path check of a memory controller. It does not touch memory itself. Instead it drives the controller's built-in data-generator test engine over a simple register port, using a write strobe, a read strobe, a 2-bit register select and 32-bit data. Read data returns one cycle after the read strobe.

One `start` pulse launches a fixed number of iterations, two by default. Each iteration:

- writes a seed word to the engine;
- updates part of the engine's test-address register by read-modify-write;
- sweeps sixteen tests: eight in the single-access phase, then eight in the burst phase, one per generator index.

Each test clears the control register, writes a composed control word, then polls the status bits until the engine reports done or error, or until a poll limit is exceeded. It then clears the control register again. The first failing test ends its iteration. When every iteration is over, the block presents the pass and fail counts and pulses `done`.

Top module: `memtest_seq`

## Requirements
- R1: After reset `busy`, `done`, `bus_wr` and `bus_rd` are 0, and both counters are 0.
- R2: Each iteration begins by writing its seed to register select 1. Iteration i uses entry i mod 8 of the list 0xcc33cc33, 0xff00ff00, 0xaa55aa55, 0x88778877, 0x92cc4d6e, 0x543d3cde, 0xf1e843c7, 0x7c61d253.
- R3: Once per iteration, the test-address register (select 2) is read and then written back. In the written value, bits 30:4 are replaced so that they equal the bits of 0x007ffff0, and bit 31 and bits 3:0 keep the value that was read.
- R4: Every nonzero write to the control register (select 0) is directly preceded by a bus write of 0 to it. Every test also ends with a write of 0 to it.
- R5: Control word encoding, with index k = 0..7:
  - single phase: 0x85 | (k<<3);
  - burst phase: 0xC1 | (k<<3), except that k = 0 uses 0x85.
- R6: Status is read from select 0, and only bits 13:12 matter. The block keeps reading while both are 0. Bit 12 alone ends the test as passed, and the sweep moves to the next test.
- R7: Status bit 13 set, alone or with bit 12, fails the test. The remaining tests of that iteration are skipped.
- R8: A test fails on timeout when its read count exceeds TIMEOUT_POLLS without bit 13. Bit 12 on read number TIMEOUT_POLLS passes; on read TIMEOUT_POLLS+1 it does not.
- R9: Exactly NUM_ITER iterations run. An iteration counts as one pass or one fail, counters clear on start, and `done` is high for exactly one cycle at the end.
- R10: `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a run when idle |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass_cnt | output | CNT_W | Iterations passed |
| fail_cnt | output | CNT_W | Iterations failed |
| bus_wr | output | 1 | Register write strobe |
| bus_rd | output | 1 | Register read strobe |
| bus_addr | output | 2 | Register select: 0 control/status, 1 seed, 2 test address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid the cycle after `bus_rd` |

## Verification
The hardest situation to reach is the timeout boundary. It needs an engine that answers on exactly the last allowed poll, or one poll too late.

The bench shortens the poll limit to 6. Its engine model holds the status at zero for a programmed number of reads on one chosen test. Running that test with 5 and then 6 silent reads lands the answer on reads 6 and 7, one on each side of the limit.

A silent engine and a simultaneous done-and-error status cover the remaining failure paths.

// File: rtl/memtest_pkg.sv
package memtest_pkg;
    localparam logic [1:0] SEL_CTRL  = 2'd0;
    localparam logic [1:0] SEL_SEED  = 2'd1;
    localparam logic [1:0] SEL_TADDR = 2'd2;

    localparam logic [31:0] TADDR_FIELD = 32'h7FFF_FFF0;
    localparam logic [31:0] TADDR_FILL  = 32'h007F_FFF0;

    localparam int GEN_COUNT = 8;
    localparam int IDX_W     = $clog2(GEN_COUNT);
    localparam int TEST_W    = IDX_W + 1;

    typedef enum logic [3:0] {
        ST_IDLE, ST_SEED, ST_ADDR_RD, ST_ADDR_WR, ST_CLR, ST_GO,
        ST_POLL_RD, ST_POLL_CHK, ST_FIN, ST_ITER_END, ST_DONE
    } seq_state_e;
endpackage

// File: rtl/memtest_seed_rom.sv
module memtest_seed_rom (
    input  logic [2:0]  idx,
    output logic [31:0] seed
);
    always_comb begin
        case (idx)
            3'd0:    seed = 32'hcc33_cc33;
            3'd1:    seed = 32'hff00_ff00;
            3'd2:    seed = 32'haa55_aa55;
            3'd3:    seed = 32'h8877_8877;
            3'd4:    seed = 32'h92cc_4d6e;
            3'd5:    seed = 32'h543d_3cde;
            3'd6:    seed = 32'hf1e8_43c7;
            default: seed = 32'h7c61_d253;
        endcase
    end
endmodule

// File: rtl/memtest_ctrl_enc.sv
module memtest_ctrl_enc
    import memtest_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    input  logic             burst,
    output logic [31:0]      word
);
    localparam logic [31:0] BASE_SINGLE = 32'h0000_0085;
    localparam logic [31:0] BASE_BURST  = 32'h0000_00C1;

    logic single;
    always_comb begin
        single = !burst || (idx == '0);
        word   = (single ? BASE_SINGLE : BASE_BURST) | (32'(idx) << 3);
    end
endmodule

// File: rtl/memtest_poll_timer.sv
module memtest_poll_timer #(
    parameter int LIMIT = 5_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic over
);
    localparam int CW = $clog2(LIMIT + 2);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (inc && cnt_q <= CW'(LIMIT))
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign over = cnt_q > CW'(LIMIT);
endmodule

// File: rtl/memtest_seq.sv
module memtest_seq
    import memtest_pkg::*;
#(
    parameter int NUM_ITER      = 2,
    parameter int TIMEOUT_POLLS = 5_000_000,
    parameter int CNT_W         = $clog2(NUM_ITER + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] pass_cnt,
    output logic [CNT_W-1:0] fail_cnt,
    output logic             bus_wr,
    output logic             bus_rd,
    output logic [1:0]       bus_addr,
    output logic [31:0]      bus_wdata,
    input  logic [31:0]      bus_rdata
);
    localparam int ITER_W = $clog2(NUM_ITER + 1);
    localparam logic [TEST_W-1:0] LAST_TEST = TEST_W'(2 * GEN_COUNT - 1);

    typedef struct packed {
        seq_state_e       st;
        logic [ITER_W-1:0] iter;
        logic [TEST_W-1:0] test;
        logic              failed;
        logic [CNT_W-1:0]  pass_n;
        logic [CNT_W-1:0]  fail_n;
    } seq_regs_t;

    seq_regs_t d, q;

    logic [31:0] iter_ext;
    logic [31:0] seed_word;
    logic [31:0] ctrl_word;
    logic        tmr_clr, tmr_inc, tmr_over;

    assign iter_ext = 32'(q.iter);

    memtest_seed_rom u_seed (
        .idx  (iter_ext[2:0]),
        .seed (seed_word)
    );

    memtest_ctrl_enc u_enc (
        .idx   (q.test[IDX_W-1:0]),
        .burst (q.test[IDX_W]),
        .word  (ctrl_word)
    );

    memtest_poll_timer #(.LIMIT(TIMEOUT_POLLS)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .inc   (tmr_inc),
        .over  (tmr_over)
    );

    always_comb begin
        d         = q;
        bus_wr    = 1'b0;
        bus_rd    = 1'b0;
        bus_addr  = SEL_CTRL;
        bus_wdata = '0;
        tmr_clr   = 1'b0;
        tmr_inc   = 1'b0;
        done      = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st     = ST_SEED;
                    d.iter   = '0;
                    d.pass_n = '0;
                    d.fail_n = '0;
                end
            end
            ST_SEED: begin
                bus_wr    = 1'b1;
                bus_addr  = SEL_SEED;
                bus_wdata = seed_word;
                d.test    = '0;
                d.failed  = 1'b0;
                d.st      = ST_ADDR_RD;
            end
            ST_ADDR_RD: begin
                bus_rd   = 1'b1;
                bus_addr = SEL_TADDR;
                d.st     = ST_ADDR_WR;
            end
            ST_ADDR_WR: begin
                bus_wr    = 1'b1;
                bus_addr  = SEL_TADDR;
                bus_wdata = (bus_rdata & ~TADDR_FIELD) | TADDR_FILL;
                d.st      = ST_CLR;
            end
            ST_CLR: begin
                bus_wr = 1'b1;
                d.st   = ST_GO;
            end
            ST_GO: begin
                bus_wr    = 1'b1;
                bus_wdata = ctrl_word;
                tmr_clr   = 1'b1;
                d.st      = ST_POLL_RD;
            end
            ST_POLL_RD: begin
                bus_rd  = 1'b1;
                tmr_inc = 1'b1;
                d.st    = ST_POLL_CHK;
            end
            ST_POLL_CHK: begin
                if (bus_rdata[13] || tmr_over) begin
                    d.failed = 1'b1;
                    d.st     = ST_FIN;
                end else if (bus_rdata[12]) begin
                    d.st = ST_FIN;
                end else begin
                    d.st = ST_POLL_RD;
                end
            end
            ST_FIN: begin
                bus_wr = 1'b1;
                if (q.failed || q.test == LAST_TEST) begin
                    d.st = ST_ITER_END;
                end else begin
                    d.test = q.test + 1'b1;
                    d.st   = ST_CLR;
                end
            end
            ST_ITER_END: begin
                if (q.failed) d.fail_n = q.fail_n + 1'b1;
                else          d.pass_n = q.pass_n + 1'b1;
                if (q.iter == ITER_W'(NUM_ITER - 1)) begin
                    d.st = ST_DONE;
                end else begin
                    d.iter = q.iter + 1'b1;
                    d.st   = ST_SEED;
                end
            end
            ST_DONE: begin
                done = 1'b1;
                d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st     <= ST_IDLE;
            q.iter   <= '0;
            q.test   <= '0;
            q.failed <= 1'b0;
            q.pass_n <= '0;
            q.fail_n <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy     = q.st != ST_IDLE;
    assign pass_cnt = q.pass_n;
    assign fail_cnt = q.fail_n;
endmodule

// File: rtl/memtest_seq_chk.sv
module memtest_seq_chk #(
    parameter int NUM_ITER = 2,
    parameter int CNT_W    = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [CNT_W-1:0] pass_cnt,
    input logic [CNT_W-1:0] fail_cnt,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic [1:0]       bus_addr,
    input logic [31:0]      bus_wdata
);
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(pass_cnt) + 32'(fail_cnt)) <= NUM_ITER);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bus_wr && !bus_rd));

    p_one_access_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd));

    p_clear_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0 && bus_wdata != 32'd0)
        |-> $past(bus_wr && bus_addr == 2'd0 && bus_wdata == 32'd0));

    p_word_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0 && bus_wdata != 32'd0)
        |-> (bus_wdata[31:8] == 24'd0 && bus_wdata[7] && bus_wdata[0]));

    p_counts_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(pass_cnt) && $stable(fail_cnt)));

    p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !done) |=> busy);
endmodule

bind memtest_seq memtest_seq_chk #(.NUM_ITER(NUM_ITER), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .pass_cnt  (pass_cnt),
    .fail_cnt  (fail_cnt),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata)
);

// File: tb/sim_memtest_seq.sv
module sim_memtest_seq;
    localparam int LIM   = 6;
    localparam int NITER = 2;
    localparam int CW    = $clog2(NITER + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic busy, done, bus_wr, bus_rd;
    logic [CW-1:0] pass_cnt, fail_cnt;
    logic [1:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;

    always #4 clk = ~clk;

    memtest_seq #(.NUM_ITER(NITER), .TIMEOUT_POLLS(LIM)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .pass_cnt(pass_cnt), .fail_cnt(fail_cnt), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    int n_checks = 0;
    int n_bad = 0;

    // engine configuration, set by tasks
    logic        load_req = 1'b0;
    logic [31:0] cfg_taddr = '0;
    int          sp_iter = -1, sp_test = -1, sp_dly = 0;
    logic [31:0] sp_val = '0;

    // engine model state
    logic [31:0] taddr_reg, ctrl_reg;
    int iter_seen, test_seen, words, enc_bad, clr_bad, seed_bad;
    int remaining, sp_reads, done_cnt;
    logic [31:0] resp;
    logic cur_sp, prev_clr;

    function automatic logic [31:0] exp_word(int k);
        int idx = k % 8;
        bit single = (k < 8) || (idx == 0);
        return (single ? 32'h85 : 32'hC1) | 32'(idx << 3);
    endfunction

    function automatic logic [31:0] exp_seed(int i);
        case (i % 8)
            0: return 32'hcc33cc33;
            1: return 32'hff00ff00;
            2: return 32'haa55aa55;
            3: return 32'h88778877;
            4: return 32'h92cc4d6e;
            5: return 32'h543d3cde;
            6: return 32'hf1e843c7;
            default: return 32'h7c61d253;
        endcase
    endfunction

    always @(posedge clk) begin
        if (load_req) begin
            taddr_reg = cfg_taddr; ctrl_reg = 0; iter_seen = 0; test_seen = 0;
            words = 0; enc_bad = 0; clr_bad = 0; seed_bad = 0; remaining = 0;
            sp_reads = 0; done_cnt = 0; resp = 0; cur_sp = 0; prev_clr = 0;
        end else begin
            if (done) done_cnt++;
            if (bus_wr) begin
                if (bus_addr == 2'd1) begin
                    if (ctrl_reg != 0) clr_bad++;
                    if (bus_wdata != exp_seed(iter_seen)) seed_bad++;
                    iter_seen++; test_seen = 0; prev_clr = 0;
                end else if (bus_addr == 2'd2) begin
                    taddr_reg = bus_wdata; prev_clr = 0;
                end else if (bus_addr == 2'd0) begin
                    if (bus_wdata == 0) prev_clr = 1;
                    else begin
                        if (!prev_clr) clr_bad++;
                        if (bus_wdata != exp_word(test_seen)) enc_bad++;
                        cur_sp = (iter_seen - 1 == sp_iter) && (test_seen == sp_test);
                        remaining = cur_sp ? sp_dly : test_seen % 3;
                        resp = cur_sp ? sp_val : 32'h1000;
                        words++; test_seen++; prev_clr = 0;
                    end
                    ctrl_reg = bus_wdata;
                end
            end
            if (bus_rd) begin
                if (bus_addr == 2'd2) bus_rdata <= taddr_reg;
                else begin
                    if (cur_sp) sp_reads++;
                    if (remaining > 0) begin
                        remaining--;
                        bus_rdata <= 32'h0000_0005;
                    end else bus_rdata <= resp | 32'h0000_0005;
                end
            end
        end
    end

    int cycles = 0;
    always @(posedge clk) cycles++;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_case(input int si, input int st, input int sd,
                            input logic [31:0] sv, input logic [31:0] ta,
                            input bit poke);
        @(negedge clk);
        sp_iter = si; sp_test = st; sp_dly = sd; sp_val = sv; cfg_taddr = ta;
        load_req = 1'b1;
        @(negedge clk);
        load_req = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (20) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (done_cnt == 0 && cycles < 150000) @(negedge clk);
        repeat (5) @(negedge clk);
    endtask

    initial begin
        bus_rdata = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(pass_cnt == 0 && fail_cnt == 0, "R1 counters", int'(pass_cnt) + int'(fail_cnt), 0);
        check(!busy && !done && !bus_wr && !bus_rd, "R1 idle outputs", int'(busy), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // all pass, start poked mid-run
        run_case(-1, -1, 0, 0, 32'hFFFF_FFFF, 1'b1);
        check(pass_cnt == 2 && fail_cnt == 0, "R9 pass count", int'(pass_cnt), 2);
        check(words == 32, "R6 full sweeps", words, 32);
        check(enc_bad == 0, "R5 control words", enc_bad, 0);
        check(clr_bad == 0 && ctrl_reg == 0, "R4 clears", clr_bad, 0);
        check(seed_bad == 0 && iter_seen == 2, "R2 seeds", seed_bad, 0);
        check(taddr_reg == 32'h807F_FFFF, "R3 field ones", int'(taddr_reg), int'(32'h807F_FFFF));
        check(done_cnt == 1, "R10 poke ignored / R9 one done", done_cnt, 1);

        // R7 error on iteration 0 test 10
        run_case(0, 10, 2, 32'h2000, 32'h0, 1'b0);
        check(pass_cnt == 1 && fail_cnt == 1, "R7 counts", int'(fail_cnt), 1);
        check(words == 27, "R7 abort", words, 27);
        check(taddr_reg == 32'h007F_FFF0, "R3 field zeros", int'(taddr_reg), int'(32'h007F_FFF0));
        check(clr_bad == 0 && ctrl_reg == 0, "R4 clear after fail", clr_bad, 0);

        // R8 silent engine on iteration 1 test 3
        run_case(1, 3, 0, 32'h0, 32'h1234_5678, 1'b0);
        check(pass_cnt == 1 && fail_cnt == 1, "R8 silent counts", int'(fail_cnt), 1);
        check(sp_reads == LIM + 1, "R8 silent reads", sp_reads, LIM + 1);
        check(words == 20, "R8 silent abort", words, 20);

        // R8 answer on the last allowed read
        run_case(0, 5, LIM - 1, 32'h1000, 32'h0, 1'b0);
        check(pass_cnt == 2 && fail_cnt == 0, "R8 edge pass", int'(pass_cnt), 2);
        check(sp_reads == LIM, "R8 edge reads", sp_reads, LIM);

        // R8 answer one read too late
        run_case(0, 5, LIM, 32'h1000, 32'h0, 1'b0);
        check(pass_cnt == 1 && fail_cnt == 1, "R8 late fail", int'(fail_cnt), 1);
        check(words == 22, "R8 late abort", words, 22);

        // R7 both status bits on the last test
        run_case(1, 15, 1, 32'h3000, 32'h0, 1'b0);
        check(pass_cnt == 1 && fail_cnt == 1, "R7 both bits", int'(fail_cnt), 1);
        check(words == 32, "R6 last test reached", words, 32);

        if (cycles >= 150000) begin
            n_checks++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        end
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end
endmodule